// File: doc/BRIEF.md
# FIFO Flag Offset Programming Unit

This block keeps the two threshold offsets that a FIFO's almost-empty and almost-full comparators use. During master reset, the level of a load-select strap picks two things. The first is a default value for both offsets. The second is how the offsets may be reprogrammed afterwards: word by word on the parallel data input, or bit by bit on a single serial input. Either offset can be read back, one word per read strobe, whichever loading method is in force.

All programming traffic is qualified by the load-select input. A parallel write, a serial shift or a readback only happens on a clock edge where load-select is high together with the matching enable. The two offsets are visited in a fixed order: almost-empty first, then almost-full, then back to almost-empty. Writes and reads each keep their own place in that order. A partial reset sends both orders back to the start and keeps the offsets and the chosen method, so a FIFO can be flushed mid-run without reprogramming.

Each offset is as wide as the FIFO address. A value that exceeds the FIFO depth minus one is clipped to depth minus one. The write and read sides are assumed to run on one shared clock.

Top module: `flag_offset_unit`

## Requirements
- R1: A master reset (`rst_n` low at a clock edge) with `load_sel` low sets both offsets to 127 (clipped as in R7), selects parallel programming, and clears `rd_data` to 0.
- R2: A master reset with `load_sel` high sets both offsets to 1023 (clipped as in R7) and selects serial programming.
- R3: In parallel mode, an edge with `load_sel` and `wr_en` both high loads `wr_data` into one offset. Successive writes go to almost-empty, then almost-full, then wrap. The other offset keeps its value.
- R4: In serial mode, an edge with `load_sel` and `ser_en` both high shifts in `ser_din`, least significant bit first. Every group of ADDR_W bits is written as a whole to almost-empty, and the next group to almost-full, then the order wraps. An offset changes only on the edge that brings in the last bit of its group.
- R5: An edge with `load_sel` and `rd_en` both high places one offset, zero-extended, on `rd_data` after that edge. Successive reads return almost-empty, then almost-full, then wrap. This works in both modes. Between reads, `rd_data` holds its value.
- R6: Parallel writes have no effect in serial mode, and serial shifts have no effect in parallel mode. With `load_sel` low, `wr_en`, `ser_en` and `rd_en` have no effect. The programming mode changes only at master reset.
- R7: Any offset, whether a default, a parallel word or a serial group, that exceeds DEPTH-1 is stored as DEPTH-1.
- R8: A partial reset (`soft_rst_n` low) leaves the offsets and the mode unchanged and ignores programming traffic during that cycle. It returns the write order, the read order and the serial bit position to their start, and clears `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared write/read clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| soft_rst_n | input | 1 | Synchronous active-low partial reset |
| load_sel | input | 1 | Default strap at master reset; qualifies programming traffic otherwise |
| ser_en | input | 1 | Serial shift enable |
| wr_en | input | 1 | Parallel write enable |
| rd_en | input | 1 | Readback enable |
| ser_din | input | 1 | Serial data bit |
| wr_data | input | DATA_W | Parallel offset word |
| ae_off | output | ADDR_W | Almost-empty offset |
| af_off | output | ADDR_W | Almost-full offset |
| rd_data | output | DATA_W | Readback word |

## Verification
The bench builds the block with DEPTH=1000 and DATA_W=12, which gives a 10-bit offset. With these values the 1023 default and the all-ones serial group both clip to 999. A parallel word can carry set bits above the offset width, so saturation from every source can be reached. DEPTH=1000 is not a power of two, so values that fit the register but exceed depth minus one are also exercised. Directed sequences cover both reset straps, the wrap of each order, a partial reset taken mid-group and mid-order, and traffic from the mode that is not selected. These are followed by free-running mixed traffic in both modes.

// File: rtl/fou_pkg.sv
// Shared types for the flag offset programming unit.
package fou_pkg;
    // Which offset register a pointer refers to.
    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } sel_e;

    // Programming method latched at master reset.
    typedef enum logic {
        PROG_PAR = 1'b0,
        PROG_SER = 1'b1
    } prog_e;
endpackage

// File: rtl/fou_toggle_ptr.sv
// One-bit round-robin pointer over the two offset registers.
// Assumes: clr_n is the combined synchronous active-low clear.
module fou_toggle_ptr (
    input  logic clk,
    input  logic clr_n,
    input  logic step,
    output logic ptr
);
    // Advance to the other register on each step, restart on clear.
    always_ff @(posedge clk) begin
        if (!clr_n)
            ptr <= 1'b0;
        else if (step)
            ptr <= ~ptr;
    end

    // R3 (write instance) / R5 (read instance): every step moves the pointer.
    a_r3_ptr_toggles: assert property (@(posedge clk) disable iff (!clr_n)
        step |=> (ptr != $past(ptr)));
endmodule

// File: rtl/fou_serial_loader.sv
// Collects serial bits, LSB first, into ADDR_W-bit groups and announces each
// completed group together with the register it is meant for.
// Assumes: shift is already qualified by mode and load select.
module fou_serial_loader
    import fou_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int CNT_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              shift,
    input  logic              si,
    output logic              commit,
    output logic              commit_sel,
    output logic [ADDR_W-1:0] commit_val
);
    logic [ADDR_W-1:0] stage_q;
    logic [CNT_W-1:0]  cnt_q;
    sel_e              sel_q;
    logic              last_bit;
    logic [ADDR_W-1:0] stage_nxt;

    // Next staging value and end-of-group detection.
    always_comb begin
        stage_nxt = {si, stage_q[ADDR_W-1:1]};
        last_bit  = (cnt_q == CNT_W'(ADDR_W - 1));
    end

    assign commit     = shift && last_bit;
    assign commit_sel = sel_q;
    assign commit_val = stage_nxt;

    // Shift register, bit position and target register.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            stage_q <= '0;
            cnt_q   <= '0;
            sel_q   <= SEL_AE;
        end else if (shift) begin
            stage_q <= stage_nxt;
            if (last_bit) begin
                cnt_q <= '0;
                sel_q <= (sel_q == SEL_AE) ? SEL_AF : SEL_AE;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R4: the bit position never passes the last bit of a group.
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!clr_n)
        cnt_q <= CNT_W'(ADDR_W - 1));
    // R4: a completed group hands the next group to the other register.
    a_r4_commit_swaps: assert property (@(posedge clk) disable iff (!clr_n)
        commit |=> (sel_q != $past(sel_q)));
endmodule

// File: rtl/flag_offset_unit.sv
// Holds the almost-empty and almost-full offsets. Defaults and the programming
// method are chosen by load_sel at master reset. Parallel writes, serial
// shifts and readback are qualified by load_sel.
// Assumes: one clock for write and read sides; DEPTH >= 2; DATA_W >= ADDR_W.
module flag_offset_unit
    import fou_pkg::*;
#(
    parameter int DEPTH  = 65536,
    parameter int DATA_W = 18,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_n,
    input  logic              load_sel,
    input  logic              ser_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              ser_din,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] ae_off,
    output logic [ADDR_W-1:0] af_off,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WIDE0 = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int WIDE  = (WIDE0 > 11) ? WIDE0 : 11;
    localparam logic [WIDE-1:0] LIMIT = WIDE'(DEPTH - 1);

    // Saturate a value to DEPTH-1 and narrow it to the offset width.
    function automatic logic [ADDR_W-1:0] clip(input logic [WIDE-1:0] v);
        clip = (v > LIMIT) ? LIMIT[ADDR_W-1:0] : v[ADDR_W-1:0];
    endfunction

    prog_e             mode_q;
    logic              live, clr_n;
    logic              par_wr, ser_shift, rd_stb;
    logic              wptr, rptr;
    logic              ser_commit, ser_sel;
    logic [ADDR_W-1:0] ser_val;
    logic [ADDR_W-1:0] dflt;
    logic [ADDR_W-1:0] off_bus [2];

    // Qualify traffic: no reset active, load select high, matching mode.
    always_comb begin
        clr_n     = rst_n && soft_rst_n;
        live      = clr_n;
        par_wr    = live && load_sel && wr_en  && (mode_q == PROG_PAR);
        ser_shift = live && load_sel && ser_en && (mode_q == PROG_SER);
        rd_stb    = live && load_sel && rd_en;
        dflt      = load_sel ? clip(WIDE'(1023)) : clip(WIDE'(127));
    end

    // Programming method, latched only during master reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= load_sel ? PROG_SER : PROG_PAR;
    end

    fou_toggle_ptr u_wptr (
        .clk   (clk),
        .clr_n (clr_n),
        .step  (par_wr),
        .ptr   (wptr)
    );

    fou_toggle_ptr u_rptr (
        .clk   (clk),
        .clr_n (clr_n),
        .step  (rd_stb),
        .ptr   (rptr)
    );

    fou_serial_loader #(.ADDR_W(ADDR_W)) u_ser (
        .clk        (clk),
        .clr_n      (clr_n),
        .shift      (ser_shift),
        .si         (ser_din),
        .commit     (ser_commit),
        .commit_sel (ser_sel),
        .commit_val (ser_val)
    );

    // One offset register per flag, each with its own load decode.
    for (genvar g = 0; g < 2; g++) begin : g_off
        logic [ADDR_W-1:0] q;
        // Default on master reset, otherwise load from whichever path targets it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= dflt;
            else if (par_wr && (wptr == 1'(g)))
                q <= clip(WIDE'(wr_data));
            else if (ser_commit && (ser_sel == 1'(g)))
                q <= clip(WIDE'(ser_val));
        end
        assign off_bus[g] = q;
    end

    assign ae_off = off_bus[0];
    assign af_off = off_bus[1];

    // Readback register: capture the offset under the read pointer.
    always_ff @(posedge clk) begin
        if (!clr_n)
            rd_data <= '0;
        else if (rd_stb)
            rd_data <= DATA_W'(off_bus[rptr]);
    end

    // R7: neither offset ever exceeds DEPTH-1.
    a_r7_ae_clip: assert property (@(posedge clk) disable iff (!rst_n)
        ae_off <= ADDR_W'(DEPTH - 1));
    a_r7_af_clip: assert property (@(posedge clk) disable iff (!rst_n)
        af_off <= ADDR_W'(DEPTH - 1));
    // R8: a partial reset keeps offsets and mode.
    a_r8_soft_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst_n |=> ($stable(ae_off) && $stable(af_off) && $stable(mode_q)));
    // R6: the mode stays put outside master reset.
    a_r6_mode_ser_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PROG_SER) |=> (mode_q == PROG_SER));
    a_r6_mode_par_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PROG_PAR) |=> (mode_q == PROG_PAR));
    // R6: in serial mode offsets move only on a completed serial group.
    a_r6_ser_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == PROG_SER) && !ser_commit) |=> ($stable(ae_off) && $stable(af_off)));
endmodule

// File: tb/flag_offset_unit_bench.sv
`timescale 1ns/1ps
module flag_offset_unit_bench;
    localparam int DEPTH  = 1000;
    localparam int DATA_W = 12;
    localparam int AW     = 10;
    localparam int LIM    = DEPTH - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0, soft_rst_n = 1'b1;
    logic load_sel = 1'b0, ser_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ser_din = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [AW-1:0]     ae_off, af_off;
    logic [DATA_W-1:0] rd_data;

    int    n_chk = 0, n_err = 0;
    string cur_req = "R1";
    bit    armed = 0, done = 0;

    // Behavioural reference state.
    int m_ae, m_af, m_mode, m_wp, m_rp, m_cnt, m_sel, m_stage, m_rd;

    always #2.5 clk = ~clk;

    flag_offset_unit #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_flag_offset_unit (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .load_sel(load_sel),
        .ser_en(ser_en), .wr_en(wr_en), .rd_en(rd_en), .ser_din(ser_din),
        .wr_data(wr_data), .ae_off(ae_off), .af_off(af_off), .rd_data(rd_data)
    );

    function automatic int clipv(int v);
        return (v > LIM) ? LIM : v;
    endfunction

    // Reference model, advanced on every rising edge from the driven inputs.
    always @(posedge clk) begin
        int v;
        if (!rst_n) begin
            armed   = 1;
            m_ae    = load_sel ? clipv(1023) : clipv(127);
            m_af    = m_ae;
            m_mode  = load_sel;
            m_wp = 0; m_rp = 0; m_cnt = 0; m_sel = 0; m_stage = 0; m_rd = 0;
        end else if (!soft_rst_n) begin
            m_wp = 0; m_rp = 0; m_cnt = 0; m_sel = 0; m_stage = 0; m_rd = 0;
        end else begin
            if (load_sel && rd_en) begin
                m_rd = m_rp ? m_af : m_ae;
                m_rp ^= 1;
            end
            if (load_sel && wr_en && m_mode == 0) begin
                v = clipv(int'(wr_data));
                if (m_wp) m_af = v; else m_ae = v;
                m_wp ^= 1;
            end
            if (load_sel && ser_en && m_mode == 1) begin
                m_stage |= (int'(ser_din) << m_cnt);
                m_cnt++;
                if (m_cnt == AW) begin
                    v = clipv(m_stage);
                    if (m_sel) m_af = v; else m_ae = v;
                    m_sel ^= 1; m_cnt = 0; m_stage = 0;
                end
            end
        end
    end

    task automatic chk(string what, logic [31:0] got, int exp);
        n_chk++;
        if ($isunknown(got) || got != exp) begin
            n_err++;
            $display("FAIL %s %s got %0d exp %0d", cur_req, what, got, exp);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            chk("ae_off", 32'(ae_off), m_ae);
            chk("af_off", 32'(af_off), m_af);
            chk("rd_data", 32'(rd_data), m_rd);
        end
    end

    task automatic drive(bit l, bit w, bit s, bit r, bit b, int d,
                         bit rn = 1, bit pn = 1, int n = 1);
        repeat (n) begin
            @(negedge clk);
            load_sel = l; wr_en = w; ser_en = s; rd_en = r; ser_din = b;
            wr_data = DATA_W'(d); rst_n = rn; soft_rst_n = pn;
        end
    endtask

    task automatic idle(int n = 1);
        drive(0, 0, 0, 0, 0, 0, 1, 1, n);
    endtask

    task automatic ser_bits(int v, int bits);
        for (int i = 0; i < bits; i++) drive(1, 0, 1, 0, bit'((v >> i) & 1), 0);
    endtask

    task automatic mixed(int n);
        for (int i = 0; i < n; i++)
            drive(($urandom % 10) < 7, $urandom % 2, $urandom % 2, $urandom % 2,
                  $urandom % 2, int'($urandom % 4096), 1, ($urandom % 40) != 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog got 0 exp 1");
            finish_run();
        end
    end

    initial begin
        // R1: master reset with strap low.
        cur_req = "R1";
        drive(0, 0, 0, 0, 0, 0, 0, 1, 2);
        idle(2);
        // R3: alternating parallel writes with wrap.
        cur_req = "R3";
        drive(1, 1, 0, 0, 0, 5);
        drive(1, 1, 0, 0, 0, 300);
        drive(1, 1, 0, 0, 0, 42);
        idle(1);
        // R7: saturation of parallel words, including bits above the offset width.
        cur_req = "R7";
        drive(1, 1, 0, 0, 0, 4000);
        drive(1, 1, 0, 0, 0, 999);
        drive(1, 1, 0, 0, 0, 1000);
        drive(1, 1, 0, 0, 0, 12'hC05);
        // R5: readback order and hold.
        cur_req = "R5";
        drive(1, 0, 0, 1, 0, 0);
        idle(2);
        drive(1, 0, 0, 1, 0, 0);
        drive(1, 0, 0, 1, 0, 0);
        idle(1);
        // R6: qualifiers low, and serial traffic in parallel mode.
        cur_req = "R6";
        drive(0, 1, 1, 1, 1, 77, 1, 1, 3);
        for (int i = 0; i < 12; i++) drive(1, 0, 1, 0, bit'(i & 1), 0);
        idle(1);
        // R8: partial reset mid-order with traffic present.
        cur_req = "R8";
        drive(1, 1, 0, 0, 0, 11);
        drive(1, 0, 0, 1, 0, 0);
        drive(1, 1, 1, 1, 1, 222, 1, 0);
        drive(1, 1, 0, 0, 0, 33);
        drive(1, 0, 0, 1, 0, 0);
        idle(1);
        // R2: master reset with strap high.
        cur_req = "R2";
        drive(1, 0, 0, 0, 0, 0, 0, 1, 2);
        idle(2);
        // R4: serial groups, LSB first, with wrap.
        cur_req = "R4";
        ser_bits(341, AW);
        idle(1);
        ser_bits(123, AW);
        ser_bits(7, AW);
        idle(1);
        // R7: serial all-ones group clips.
        cur_req = "R7";
        ser_bits(1023, AW);
        // R6: parallel writes in serial mode.
        cur_req = "R6";
        drive(1, 1, 0, 0, 0, 55, 1, 1, 3);
        // R5: readback in serial mode.
        cur_req = "R5";
        drive(1, 0, 0, 1, 0, 0, 1, 1, 3);
        // R8: partial reset in the middle of a group.
        cur_req = "R8";
        ser_bits(15, 4);
        drive(1, 0, 1, 0, 1, 0, 1, 0);
        ser_bits(20, AW);
        idle(1);
        // Mixed traffic in serial mode, then parallel mode.
        cur_req = "R4";
        mixed(300);
        cur_req = "R1";
        drive(0, 0, 0, 0, 0, 0, 0, 1, 2);
        cur_req = "R3";
        mixed(300);
        idle(2);
        finish_run();
    end
endmodule